// File: doc/BRIEF.md
# LED String Fault Supervisor

This block watches every string of a multi-string LED driver and decides, per string, whether it is healthy, suspected open, suspected short or switched off. Each string reports two comparator results: its pin voltage is above the short threshold, and its current source has reached the target current. Shared inputs report output over-voltage, over-temperature and input undervoltage. Two timing inputs supply the count events: a dimming-period tick and the raw input PWM.

A string that is suspected of a fault is not switched off at once. It is switched off only after a number of count events, so that short transients do not remove a healthy string. In phase-shifted dimming the count event is the period tick and the limit is fixed. In direct dimming the count event is each rising edge of the input PWM, and the limit is a programmable value that is held inside a fixed window. Detection is paused while the regulation loop reports that it is not yet stable.

An over-temperature event turns off every string and the boost. An undervoltage event clears everything, and operation resumes only after a new rising edge on the enable input.

Top module: `led_fault_supervisor`

## Requirements
- R1: While reset is applied, and afterwards until the block is started, `boost_stop` is 1 and every bit of `ch_disable` is 1. Whenever `boost_stop` is 1, every bit of `ch_disable` is 1.
- R2: When the block is stopped, a rising edge of `enable` (high in this cycle, low in the previous cycle) with `uvlo_flag` low starts it. From the next cycle `boost_stop` is 0, and every channel starts in the not-yet-good state with its `ch_disable` bit 0.
- R3: A not-yet-good channel whose `reached` bit is 1 becomes good. A good channel whose `reached` bit falls to 0 becomes a suspected open, with its count at zero. A suspected open whose `reached` bit returns to 1 becomes good again, and its count is cleared.
- R4: In a cycle where `ovp_flag` is 1, every channel that is still not-yet-good becomes a suspected open. Good channels are not affected.
- R5: A channel whose `short_flag` bit is 1 becomes a suspected short, whatever its `reached` bit is. A suspected short whose `short_flag` falls to 0 returns to not-yet-good, and its count is cleared.
- R6: With `direct_mode` at 0, each cycle in which `period_tick` is 1 adds one to a suspected channel's count. The 6th such tick after the channel became suspected switches the channel off, and its `ch_disable` bit becomes 1 from the next cycle.
- R7: With `direct_mode` at 1, `period_tick` is ignored. The count event is instead each rising edge of `pwm_in`, and the limit is `dir_timeout` clamped to the range 7 to 18.
- R8: A channel that has been switched off stays off whatever its inputs do, until undervoltage or reset. The other channels keep their own states.
- R9: While `stable` is 0, no channel changes state or count.
- R10: When `otp_flag` is 1 while the block is running, `boost_stop` and all of `ch_disable` become 1 from the next cycle. They stay at 1 after `otp_flag` falls, until undervoltage.
- R11: When `uvlo_flag` is 1, the block stops from the next cycle and clears every channel, including channels that were switched off. It restarts only on a later rising edge of `enable`. If `enable` stays high, the block stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Start request; the block starts on its rising edge |
| uvlo_flag | input | 1 | Input undervoltage detected |
| otp_flag | input | 1 | Over-temperature detected |
| ovp_flag | input | 1 | Output over-voltage detected |
| stable | input | 1 | Regulation is settled; fault detection is allowed |
| direct_mode | input | 1 | 1 selects direct dimming, 0 selects phase-shifted dimming |
| period_tick | input | 1 | One-cycle pulse once per dimming period |
| pwm_in | input | 1 | Input PWM, already synchronous to `clk` |
| dir_timeout | input | CNT_W | Requested timeout for direct dimming, in PWM edges |
| short_flag | input | NUM_CH | Per channel: pin voltage is above the short threshold |
| reached | input | NUM_CH | Per channel: current source is at target |
| ch_disable | output | NUM_CH | Per channel: string is turned off |
| boost_stop | output | 1 | Boost switching must stop |

## Verification
The bench checks four kinds of corner cases.
- Counter reset. The bench lets a suspected open return to good partway through its count and then fall again. A design that keeps the old count switches the string off too early.
- Event source. In direct dimming the bench sends period ticks, which must not count. It also sets requested timeouts below, inside and above the allowed window, and checks that the string is switched off exactly on the clamped edge. A design that counts the wrong event, or does not clamp, switches off on the wrong edge.
- Frozen timers. The bench holds `stable` low while ticks arrive, so a design that keeps counting would switch the string off early. It also sends over-voltage while some strings are already good, so a design that marks every string open would switch healthy strings off.
- Restart. After undervoltage, the bench holds `enable` high and checks that the block stays stopped. A design that restarts on a level instead of an edge would restart here, and one that does not clear the switched-off strings would leave them off after the restart.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

   // Classification of one LED string.
   typedef enum logic [2:0] {
      CH_IDLE  = 3'd0,   // not yet good
      CH_GOOD  = 3'd1,
      CH_OPEN  = 3'd2,   // suspected open
      CH_SHORT = 3'd3,   // suspected short
      CH_OFF   = 3'd4    // switched off, latched
   } ch_state_e;

endpackage

// File: rtl/lfs_global_ctrl.sv
// Run / lockout control shared by all strings.
module lfs_global_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic uvlo_i,
   input  logic otp_i,
   output logic active_o,
   output logic otp_lat_o
);

   logic en_q;
   logic en_rise;

   assign en_rise = enable_i & ~en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         active_o  <= 1'b0;
         otp_lat_o <= 1'b0;
      end else begin
         en_q <= enable_i;
         if (uvlo_i) begin
            active_o  <= 1'b0;
            otp_lat_o <= 1'b0;
         end else begin
            if (!active_o && en_rise)
               active_o <= 1'b1;
            if (active_o && otp_i)
               otp_lat_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/lfs_tick_gen.sv
// Selects the count event and the timeout limit for the active dimming mode.
module lfs_tick_gen #(
   parameter int CNT_W       = 5,
   parameter int PS_TIMEOUT  = 6,
   parameter int DIR_MIN     = 7,
   parameter int DIR_MAX     = 18,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   input  logic             period_tick,
   input  logic             direct_mode,
   input  logic [CNT_W-1:0] dir_timeout,
   output logic             tick_o,
   output logic [CNT_W-1:0] limit_o
);

   localparam logic [CNT_W-1:0] PS_LIM  = CNT_W'(PS_TIMEOUT);
   localparam logic [CNT_W-1:0] DIR_LO  = CNT_W'(DIR_MIN);
   localparam logic [CNT_W-1:0] DIR_HI  = CNT_W'(DIR_MAX);

   logic pwm_s;
   logic pwm_q;
   logic pwm_rise;
   logic [CNT_W-1:0] dir_lim;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pwm_s = pwm_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= pwm_in;
               for (int k = 1; k < SYNC_STAGES; k++)
                  sr[k] <= sr[k-1];
            end
         end
         assign pwm_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= pwm_s;
   end

   assign pwm_rise = pwm_s & ~pwm_q;

   always_comb begin
      if (dir_timeout < DIR_LO)      dir_lim = DIR_LO;
      else if (dir_timeout > DIR_HI) dir_lim = DIR_HI;
      else                           dir_lim = dir_timeout;
   end

   assign tick_o  = direct_mode ? pwm_rise : period_tick;
   assign limit_o = direct_mode ? dir_lim  : PS_LIM;

endmodule

// File: rtl/lfs_channel.sv
// Fault classification and timeout for one string.
module lfs_channel
   import lfs_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             freeze_i,
   input  logic             short_i,
   input  logic             reached_i,
   input  logic             ovp_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             off_o
);

   ch_state_e        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W:0]   cnt_inc;
   logic             expire;

   assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign expire  = cnt_inc >= {1'b0, limit_i};

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (clear_i) begin
         st_d  = CH_IDLE;
         cnt_d = '0;
      end else if (!freeze_i && st_q != CH_OFF) begin
         if (short_i && st_q != CH_SHORT) begin
            st_d  = CH_SHORT;
            cnt_d = '0;
         end else begin
            unique case (st_q)
               CH_IDLE: begin
                  if (reached_i)  st_d = CH_GOOD;
                  else if (ovp_i) begin
                     st_d  = CH_OPEN;
                     cnt_d = '0;
                  end
               end
               CH_GOOD: begin
                  if (!reached_i) begin
                     st_d  = CH_OPEN;
                     cnt_d = '0;
                  end
               end
               CH_OPEN: begin
                  if (reached_i) begin
                     st_d  = CH_GOOD;
                     cnt_d = '0;
                  end else if (tick_i) begin
                     if (expire) st_d = CH_OFF;
                     else        cnt_d = cnt_inc[CNT_W-1:0];
                  end
               end
               CH_SHORT: begin
                  if (!short_i) begin
                     st_d  = CH_IDLE;
                     cnt_d = '0;
                  end else if (tick_i) begin
                     if (expire) st_d = CH_OFF;
                     else        cnt_d = cnt_inc[CNT_W-1:0];
                  end
               end
               default: begin
                  st_d  = st_q;
                  cnt_d = cnt_q;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CH_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign off_o = (st_q == CH_OFF);

endmodule

// File: rtl/led_fault_supervisor.sv
// Per-string fault supervisor for a multi-string LED driver.
module led_fault_supervisor #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 5,
   parameter int PS_TIMEOUT  = 6,
   parameter int DIR_MIN     = 7,
   parameter int DIR_MAX     = 18,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              uvlo_flag,
   input  logic              otp_flag,
   input  logic              ovp_flag,
   input  logic              stable,
   input  logic              direct_mode,
   input  logic              period_tick,
   input  logic              pwm_in,
   input  logic [CNT_W-1:0]  dir_timeout,
   input  logic [NUM_CH-1:0] short_flag,
   input  logic [NUM_CH-1:0] reached,
   output logic [NUM_CH-1:0] ch_disable,
   output logic              boost_stop
);

   localparam int CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (NUM_CH < 1) begin : g_err_nch
         $error("NUM_CH must be at least 1");
      end
      if (PS_TIMEOUT < 1 || PS_TIMEOUT > CNT_MAX) begin : g_err_ps
         $error("PS_TIMEOUT must fit in CNT_W and be at least 1");
      end
      if (DIR_MIN < 1 || DIR_MIN > DIR_MAX || DIR_MAX > CNT_MAX) begin : g_err_dir
         $error("direct timeout window is not valid for CNT_W");
      end
      if (SYNC_STAGES < 0) begin : g_err_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              active;
   logic              otp_lat;
   logic              tick;
   logic [CNT_W-1:0]  limit;
   logic              ch_clear;
   logic              ch_freeze;
   logic [NUM_CH-1:0] chan_off;

   lfs_global_ctrl u_global (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (enable),
      .uvlo_i    (uvlo_flag),
      .otp_i     (otp_flag),
      .active_o  (active),
      .otp_lat_o (otp_lat)
   );

   lfs_tick_gen #(
      .CNT_W       (CNT_W),
      .PS_TIMEOUT  (PS_TIMEOUT),
      .DIR_MIN     (DIR_MIN),
      .DIR_MAX     (DIR_MAX),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk         (clk),
      .rst_n       (rst_n),
      .pwm_in      (pwm_in),
      .period_tick (period_tick),
      .direct_mode (direct_mode),
      .dir_timeout (dir_timeout),
      .tick_o      (tick),
      .limit_o     (limit)
   );

   assign ch_clear  = ~active | uvlo_flag;
   assign ch_freeze = otp_lat | ~stable;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         lfs_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (ch_clear),
            .freeze_i  (ch_freeze),
            .short_i   (short_flag[i]),
            .reached_i (reached[i]),
            .ovp_i     (ovp_flag),
            .tick_i    (tick),
            .limit_i   (limit),
            .off_o     (chan_off[i])
         );
      end
   endgenerate

   assign boost_stop = ~active | otp_lat;
   assign ch_disable = {NUM_CH{boost_stop}} | chan_off;

endmodule

// File: rtl/led_fault_supervisor_chk.sv
module led_fault_supervisor_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              uvlo_flag,
   input logic              otp_flag,
   input logic              stable,
   input logic              active,
   input logic [NUM_CH-1:0] ch_disable,
   input logic              boost_stop,
   input logic [NUM_CH-1:0] chan_off
);

   AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      boost_stop |-> (&ch_disable)); // R1

   AST_EDGE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && $rose(enable) && !uvlo_flag) |=> (active && !boost_stop)); // R2

   AST_OFF_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !uvlo_flag |=> ((chan_off & $past(chan_off)) == $past(chan_off))); // R8

   AST_FREEZE_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stable && active && !uvlo_flag) |=> (chan_off == $past(chan_off))); // R9

   AST_OTP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (otp_flag && active && !uvlo_flag) |=> boost_stop); // R10

   AST_UVLO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_flag |=> (boost_stop && (&ch_disable) && (chan_off == '0))); // R11

endmodule

bind led_fault_supervisor led_fault_supervisor_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .uvlo_flag  (uvlo_flag),
   .otp_flag   (otp_flag),
   .stable     (stable),
   .active     (active),
   .ch_disable (ch_disable),
   .boost_stop (boost_stop),
   .chan_off   (chan_off)
);

// File: tb/led_fault_supervisor_bench.sv
`timescale 1ns/1ps
module led_fault_supervisor_bench;

   localparam int NCH = 4;
   localparam int CW  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, uvlo = 1'b0, otp = 1'b0, ovp = 1'b0;
   logic stable = 1'b1, direct = 1'b0, ptick = 1'b0, pwm = 1'b0;
   logic [CW-1:0]  dtmo = '0;
   logic [NCH-1:0] shortf = '0, reach = '0;
   logic [NCH-1:0] ch_disable;
   logic           boost_stop;

   always #2 clk = ~clk;   // 250 MHz

   led_fault_supervisor u_led_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .enable(enable), .uvlo_flag(uvlo),
      .otp_flag(otp), .ovp_flag(ovp), .stable(stable), .direct_mode(direct),
      .period_tick(ptick), .pwm_in(pwm), .dir_timeout(dtmo),
      .short_flag(shortf), .reached(reach),
      .ch_disable(ch_disable), .boost_stop(boost_stop));

   int tests = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference: 0 idle, 1 good, 2 open, 3 short, 4 off
   int m_st[NCH];
   int m_cnt[NCH];
   bit m_active, m_otp, m_en_q, m_pwm_q;
   bit m_tk, m_clr, m_frz;
   int m_lim;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
         m_active = 0; m_otp = 0; m_en_q = 0; m_pwm_q = 0;
      end else begin
         m_tk  = direct ? (pwm && !m_pwm_q) : ptick;
         if (!direct) m_lim = 6;
         else if (int'(dtmo) < 7) m_lim = 7;
         else if (int'(dtmo) > 18) m_lim = 18;
         else m_lim = int'(dtmo);
         m_clr = !m_active || uvlo;
         m_frz = m_otp || !stable;
         for (int i = 0; i < NCH; i++) begin
            if (m_clr) begin
               m_st[i] = 0; m_cnt[i] = 0;
            end else if (!m_frz && m_st[i] != 4) begin
               if (shortf[i] && m_st[i] != 3) begin
                  m_st[i] = 3; m_cnt[i] = 0;
               end else if (m_st[i] == 0) begin
                  if (reach[i]) m_st[i] = 1;
                  else if (ovp) begin m_st[i] = 2; m_cnt[i] = 0; end
               end else if (m_st[i] == 1) begin
                  if (!reach[i]) begin m_st[i] = 2; m_cnt[i] = 0; end
               end else if (m_st[i] == 2 && reach[i]) begin
                  m_st[i] = 1; m_cnt[i] = 0;
               end else if (m_st[i] == 3 && !shortf[i]) begin
                  m_st[i] = 0; m_cnt[i] = 0;
               end else if (m_tk) begin
                  if (m_cnt[i] + 1 >= m_lim) m_st[i] = 4;
                  else m_cnt[i] = m_cnt[i] + 1;
               end
            end
         end
         if (uvlo) begin
            m_active = 0; m_otp = 0;
         end else begin
            if (m_active && otp) m_otp = 1;
            if (!m_active && enable && !m_en_q) m_active = 1;
         end
         m_en_q  = enable;
         m_pwm_q = pwm;
      end
   end

   // compare against the reference on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NCH-1:0] exp_dis;
         logic           exp_stop;
         exp_stop = !m_active || m_otp;
         for (int i = 0; i < NCH; i++) exp_dis[i] = exp_stop || (m_st[i] == 4);
         tests++;
         if (exp_dis !== ch_disable || exp_stop !== boost_stop) begin
            fails++;
            $display("FAIL %s model compare: actual dis=%b stop=%b expected dis=%b stop=%b",
                     cur_req, ch_disable, boost_stop, exp_dis, exp_stop);
         end
      end
   end

   task automatic chk(string req, logic [NCH-1:0] exp_dis, logic exp_stop);
      tests++;
      if (ch_disable !== exp_dis || boost_stop !== exp_stop) begin
         fails++;
         $display("FAIL %s directed: actual dis=%b stop=%b expected dis=%b stop=%b",
                  req, ch_disable, boost_stop, exp_dis, exp_stop);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) ptick = 1'b1;
         @(negedge clk) ptick = 1'b0;
      end
   endtask

   task automatic edges(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) pwm = 1'b1;
         @(negedge clk) pwm = 1'b0;
      end
   endtask

   // undervoltage, hold enable, then a fresh enable edge
   task automatic restart();
      cur_req = "R11";
      uvlo = 1'b1; idle(1);
      chk("R11", 4'hF, 1'b1);
      uvlo = 1'b0; idle(4);
      chk("R11", 4'hF, 1'b1);        // enable still high: no restart
      enable = 1'b0; idle(1);
      enable = 1'b1; idle(1);
      chk("R11", 4'h0, 1'b0);
   endtask

   initial begin
      // R1: reset and stopped state
      idle(3);
      chk("R1", 4'hF, 1'b1);
      rst_n = 1'b1;
      idle(3);
      chk("R1", 4'hF, 1'b1);

      // R2: start on enable edge
      cur_req = "R2";
      enable = 1'b1; idle(1);
      chk("R2", 4'h0, 1'b0);

      // R3 / R6: good, open, counter clear, timeout of 6
      cur_req = "R3";
      reach = 4'hF; idle(2);
      reach[0] = 1'b0; idle(1);
      ticks(3);
      reach[0] = 1'b1; idle(1);
      reach[0] = 1'b0; idle(1);
      ticks(5);
      chk("R3", 4'h0, 1'b0);          // count was cleared, only 5 ticks
      cur_req = "R6";
      ticks(1);
      chk("R6", 4'h1, 1'b0);
      cur_req = "R8";
      reach[0] = 1'b1; idle(3);
      chk("R8", 4'h1, 1'b0);

      // R4: over-voltage marks only not-yet-good strings
      reach = 4'b1100;
      restart();
      cur_req = "R4";
      idle(1);
      ovp = 1'b1; idle(1);
      ovp = 1'b0;
      ticks(5);
      chk("R4", 4'h0, 1'b0);
      ticks(1);
      chk("R4", 4'b0011, 1'b0);

      // R5 / R9: short, freeze while unstable
      reach = 4'hF;
      restart();
      idle(1);
      cur_req = "R5";
      shortf[2] = 1'b1; idle(1);
      cur_req = "R9";
      stable = 1'b0;
      ticks(10);
      chk("R9", 4'h0, 1'b0);
      stable = 1'b1;
      ticks(5);
      chk("R9", 4'h0, 1'b0);
      cur_req = "R5";
      ticks(1);
      chk("R5", 4'b0100, 1'b0);
      shortf[3] = 1'b1; idle(1);
      ticks(3);
      shortf[3] = 1'b0; idle(2);
      shortf[3] = 1'b1; idle(1);
      ticks(5);
      chk("R5", 4'b0100, 1'b0);       // short count restarted
      cur_req = "R8";
      ticks(1);
      chk("R8", 4'b1100, 1'b0);
      shortf = '0;

      // R7: direct dimming, PWM edges, clamped limit
      direct = 1'b1; dtmo = 5'd3;
      restart();
      idle(1);
      cur_req = "R7";
      reach[0] = 1'b0; idle(1);
      ticks(10);
      chk("R7", 4'h0, 1'b0);          // period ticks ignored
      edges(6);
      chk("R7", 4'h0, 1'b0);
      edges(1);
      chk("R7", 4'h1, 1'b0);          // clamped up to 7
      dtmo = 5'd25;
      reach[1] = 1'b0; idle(1);
      edges(17);
      chk("R7", 4'h1, 1'b0);
      edges(1);
      chk("R7", 4'h3, 1'b0);          // clamped down to 18
      dtmo = 5'd10;
      reach[2] = 1'b0; idle(1);
      edges(9);
      chk("R7", 4'h3, 1'b0);
      edges(1);
      chk("R7", 4'h7, 1'b0);          // in range: 10
      direct = 1'b0;

      // R10: over-temperature, sticky until undervoltage
      cur_req = "R10";
      otp = 1'b1; idle(1);
      otp = 1'b0;
      chk("R10", 4'hF, 1'b1);
      idle(5);
      chk("R10", 4'hF, 1'b1);
      reach = 4'hF;
      restart();
      idle(2);
      chk("R11", 4'h0, 1'b0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL %s watchdog: actual=hung expected=finished", cur_req);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule